// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block lets an external master on a two-wire serial bus (SCL clock, open-drain SDA data) read and write a bank of 16-bit configuration registers that sit outside the block. It oversamples both bus lines on the system clock and detects start and stop conditions. It answers to one fixed 7-bit device address, and it turns each byte sequence into register-port operations. Register addresses are 8 bits wide. The register bank is reached through a registered write strobe and a combinational read address/data pair.

The bus carries a word as two bytes, upper byte first. A write commits a word only once its second byte has been acknowledged. The register pointer advances after each complete word, so a burst covers consecutive registers. A master that can move only single bytes sends the upper byte to the target register. It then completes or fetches the lower byte through a staging location at register address 0x80. A read starts from whatever pointer the last write-mode access left behind, and it ends when the master declines to acknowledge.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset the block leaves SDA released (sda_oe low), issues no register write, and its register pointer is 0x00, so a read with no preceding register address returns register 0x00.
- R2: A start condition (SDA falling while SCL is high) restarts byte framing at any point, including in the middle of a byte. A stop condition (SDA rising while SCL is high) releases SDA and returns the block to idle.
- R3: The block acknowledges the address byte 0xBA (write) and 0xBB (read) by pulling SDA low during the ninth clock pulse. For any other address byte it acknowledges nothing, drives nothing and writes nothing until the next start or stop.
- R4: sda_oe changes only while the synchronised SCL is low.
- R5: In a write, the byte after the address byte loads the register pointer. Later bytes are data, upper byte first, and every byte of a write is acknowledged.
- R6: A register is written only when the second byte of its word is acknowledged. A lone upper byte followed by a stop produces no write.
- R7: After each complete 16-bit word the pointer increments, so a burst fills consecutive registers.
- R8: In a read (0xBB after a start or repeated start), the slave shifts out the addressed register MSB first, upper byte then lower byte, then continues with the next register.
- R9: In a read, a master acknowledge (SDA low on the ninth pulse) loads the next byte. A no-acknowledge releases SDA and makes the slave ignore further clocks until a start.
- R10: A byte written while the pointer is 0x80 is taken as the lower half of the pending upper byte. It writes {pending upper byte, this byte} to the register where that upper byte was received. With no pending upper byte it writes nothing.
- R11: Sending an upper byte in a read copies that register's lower byte into a staging register. A read at pointer 0x80 returns the staged byte.
- R12: reg_wr_en is a single-cycle pulse for each committed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_rd_addr | output | 8 | Register pointer presented to the bank for reads |
| reg_rd_data | input | 16 | Combinational contents of the register at reg_rd_addr |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | 8 | Register to write |
| reg_wr_data | output | 16 | Word to write |

## Verification
The hardest situation to reach from the ports is the single-byte write path. In that path the pending upper byte has to survive a stop, a new start and a new register address before a byte at 0x80 completes it. The bench reaches it by ending a burst on an odd byte count, then sending a separate two-transaction sequence to 0x80. It follows that with a second 0x80 write that must produce no strobe. Restarting framing mid-byte is reached by aborting an address byte after four bits with a repeated start. A final read with no register address checks where the pointer ended up.

// File: rtl/twi_reg_pkg.sv
// Shared constants and the protocol state encoding for the two-wire register slave.
package twi_reg_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_MACK,
        ST_SKIP
    } proto_st_t;
endpackage

// File: rtl/twi_line_cond.sv
// Line conditioner: synchronises SCL and SDA into the system clock domain and
// derives SCL edges plus start/stop conditions.
// Assumes SCL high and low phases each span several system clocks.
module twi_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First synchroniser flop, idles high like the bus
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[0] <= 1'b1;
                    sda_pipe[0] <= 1'b1;
                end else begin
                    scl_pipe[0] <= scl_i;
                    sda_pipe[0] <= sda_i;
                end
            end
        end else begin : g_next
            // Later synchroniser flops
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[i] <= 1'b1;
                    sda_pipe[i] <= 1'b1;
                end else begin
                    scl_pipe[i] <= scl_pipe[i-1];
                    sda_pipe[i] <= sda_pipe[i-1];
                end
            end
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous-sample registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_proto_fsm.sv
// Bus protocol engine: frames bytes, matches the device address, drives the
// acknowledge and read-data bits, and emits one-cycle byte events to the
// word controller. Assumes tx_byte is valid combinationally when requested.
module twi_proto_fsm
    import twi_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              addr_ld,
    output logic              wr_byte,
    output logic              rd_adv,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    proto_st_t             st;
    logic [BITCNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]     sr;
    logic                  full;
    logic                  rw;
    logic                  nack;

    assign rx_byte = sr;

    // Protocol sequencing; start and stop override every state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            sr      <= '0;
            full    <= 1'b0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            sda_oe  <= 1'b0;
            addr_ld <= 1'b0;
            wr_byte <= 1'b0;
            rd_adv  <= 1'b0;
        end else begin
            addr_ld <= 1'b0;
            wr_byte <= 1'b0;
            rd_adv  <= 1'b0;
            if (start_det) begin
                st     <= ST_DEV;
                cnt    <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_REG, ST_WDAT: begin
                        if (scl_rise && !full) begin
                            sr  <= {sr[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (st == ST_DEV) begin
                                if (sr[BYTE_W-1:1] == DEV_ADDR) begin
                                    rw     <= sr[0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_DEV_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else if (st == ST_REG) begin
                                addr_ld <= 1'b1;
                                sda_oe  <= 1'b1;
                                st      <= ST_REG_ACK;
                            end else begin
                                wr_byte <= 1'b1;
                                sda_oe  <= 1'b1;
                                st      <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                sr     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                rd_adv <= 1'b1;
                                cnt    <= '0;
                                st     <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise && !full) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) full <= 1'b1;
                        end else if (scl_fall) begin
                            if (full) begin
                                full   <= 1'b0;
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                            end else begin
                                sr     <= {sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                sr     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                rd_adv <= 1'b1;
                                cnt    <= '0;
                                st     <= ST_RDAT;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_word_ctrl.sv
// Word controller: owns the register pointer, the byte phase, the pending
// upper byte for deferred writes and the lower-byte read staging. Turns byte
// events into register-port traffic. Assumes events arrive one per cycle at most.
module twi_word_ctrl
    import twi_reg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOWB_ADDR = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic              addr_ld,
    input  logic              wr_byte,
    input  logic              rd_adv,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] reg_rd_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [WORD_W-1:0] reg_wr_data
);
    logic [BYTE_W-1:0] ptr;
    logic              lo_phase;
    logic [BYTE_W-1:0] hold_hi;
    logic [BYTE_W-1:0] hold_addr;
    logic              hold_vld;
    logic [BYTE_W-1:0] stage_lo;
    logic              at_lowb;

    assign at_lowb     = (ptr == LOWB_ADDR);
    assign reg_rd_addr = ptr;
    assign tx_byte     = (at_lowb || lo_phase) ? stage_lo : reg_rd_data[WORD_W-1:BYTE_W];

    // Pointer, phase, pending-word and staging updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr         <= '0;
            lo_phase    <= 1'b0;
            hold_hi     <= '0;
            hold_addr   <= '0;
            hold_vld    <= 1'b0;
            stage_lo    <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (sess_start) lo_phase <= 1'b0;
            if (addr_ld) begin
                ptr      <= rx_byte;
                lo_phase <= 1'b0;
            end else if (wr_byte) begin
                if (at_lowb) begin
                    if (hold_vld) begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_addr <= hold_addr;
                        reg_wr_data <= {hold_hi, rx_byte};
                        hold_vld    <= 1'b0;
                    end
                end else if (!lo_phase) begin
                    hold_hi   <= rx_byte;
                    hold_addr <= ptr;
                    hold_vld  <= 1'b1;
                    lo_phase  <= 1'b1;
                end else begin
                    reg_wr_en   <= 1'b1;
                    reg_wr_addr <= ptr;
                    reg_wr_data <= {hold_hi, rx_byte};
                    hold_vld    <= 1'b0;
                    lo_phase    <= 1'b0;
                    ptr         <= ptr + 1'b1;
                end
            end else if (rd_adv && !at_lowb) begin
                if (!lo_phase) begin
                    stage_lo <= reg_rd_data[BYTE_W-1:0];
                    lo_phase <= 1'b1;
                end else begin
                    lo_phase <= 1'b0;
                    ptr      <= ptr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/twi_reg_slave.sv
// Top level: two-wire serial slave giving word access to an external 16-bit
// register bank. Assumes the system clock oversamples SCL by a wide margin
// and that the pad drives SDA low whenever sda_oe is high.
module twi_reg_slave
    import twi_reg_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h5D,
    parameter logic [BYTE_W-1:0] LOWB_ADDR   = 8'h80,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [WORD_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [WORD_W-1:0] reg_wr_data
);
    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              addr_ld;
    logic              wr_byte;
    logic              rd_adv;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;

    twi_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_sync),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .addr_ld   (addr_ld),
        .wr_byte   (wr_byte),
        .rd_adv    (rd_adv),
        .rx_byte   (rx_byte)
    );

    twi_word_ctrl #(.LOWB_ADDR(LOWB_ADDR)) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .sess_start  (start_det),
        .addr_ld     (addr_ld),
        .wr_byte     (wr_byte),
        .rd_adv      (rd_adv),
        .rx_byte     (rx_byte),
        .reg_rd_data (reg_rd_data),
        .tx_byte     (tx_byte),
        .reg_rd_addr (reg_rd_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data)
    );
endmodule

// File: rtl/twi_reg_slave_chk.sv
// Property checker for the two-wire register slave, attached by bind.
module twi_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sync,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic start_det,
    input logic stop_det
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !reg_wr_en));

    // R4
    sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_sync);

    // R12
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R2
    cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_sync  (scl_sync),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/tb_twi_reg_slave.sv
// Bench: a bit-level bus master, a behavioural register bank, and a per-clock
// comparison of every write strobe against a queue of expected writes.
module tb_twi_reg_slave;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  reg_rd_addr;
    logic [15:0] reg_rd_data;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_addr;
    logic [15:0] reg_wr_data;

    logic [15:0] bank [256];
    logic [15:0] mdl  [256];
    logic [23:0] exp_q [$];

    int tests = 0;
    int fails = 0;
    int r4_bad = 0;
    int r12_bad = 0;
    logic prev_oe = 1'b0;
    logic prev_we = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line    = m_sda & ~sda_oe;
    assign reg_rd_data = bank[reg_rd_addr];

    twi_reg_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data)
    );

    function automatic logic [15:0] init_val(int i);
        return 16'(i * 257) ^ 16'h5A3C;
    endfunction

    // Register bank collaborator
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bank[i] <= init_val(i);
        end else if (reg_wr_en) begin
            bank[reg_wr_addr] <= reg_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Per-clock comparison of writes, SDA timing and strobe width
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe != prev_oe && scl) r4_bad++;
            if (reg_wr_en && prev_we) r12_bad++;
            if (reg_wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", int'({reg_wr_addr, reg_wr_data}), 0);
                end else begin
                    automatic logic [23:0] e = exp_q.pop_front();
                    chk({reg_wr_addr, reg_wr_data} == e, "R6/R7/R10 write",
                        int'({reg_wr_addr, reg_wr_data}), int'(e));
                end
            end
            prev_oe <= sda_oe;
            prev_we <= reg_wr_en;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        m_sda = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        m_sda = 1'b0; tick(H);
        scl = 1'b0;   tick(H);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic b_bit(input logic b, output logic s);
        tick(H/2); m_sda = b;
        tick(H/2); scl = 1'b1;
        tick(H/2); s = sda_line;
        tick(H/2); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) b_bit(v[i], s);
        b_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            b_bit(1'b1, s);
            v[i] = s;
        end
        b_bit(~mack, s);
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [15:0] d);
        exp_q.push_back({a, d});
        mdl[a] = d;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mdl[i] = init_val(i);
        tick(5);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(reg_wr_en == 1'b0, "R1 wr_en", int'(reg_wr_en), 0);
        rst_n = 1'b1;
        tick(5);
        chk(reg_rd_addr == 8'h00, "R1 pointer", int'(reg_rd_addr), 0);

        // R1/R8: read with no register address starts at 0x00
        b_start();
        send_byte(8'hBB, ack); chk(ack, "R3 read addr ack", int'(ack), 1);
        recv_byte(1'b1, v); chk(v == mdl[0][15:8], "R1 read hi", int'(v), int'(mdl[0][15:8]));
        recv_byte(1'b0, v); chk(v == mdl[0][7:0], "R8 read lo", int'(v), int'(mdl[0][7:0]));
        b_stop();

        // R5/R6/R7: burst write with an odd trailing byte
        b_start();
        send_byte(8'hBA, ack); chk(ack, "R3 write addr ack", int'(ack), 1);
        send_byte(8'h10, ack); chk(ack, "R5 reg addr ack", int'(ack), 1);
        expect_wr(8'h10, 16'h1234);
        expect_wr(8'h11, 16'h5678);
        send_byte(8'h12, ack); chk(ack, "R5 data ack", int'(ack), 1);
        send_byte(8'h34, ack); chk(ack, "R5 data ack", int'(ack), 1);
        send_byte(8'h56, ack); chk(ack, "R7 data ack", int'(ack), 1);
        send_byte(8'h78, ack); chk(ack, "R7 data ack", int'(ack), 1);
        send_byte(8'h9A, ack); chk(ack, "R6 lone byte ack", int'(ack), 1);
        b_stop();
        tick(4);
        chk(exp_q.size() == 0, "R6 burst writes done", exp_q.size(), 0);

        // R10: lower byte through 0x80 completes the pending word at 0x12
        b_start();
        send_byte(8'hBA, ack);
        send_byte(8'h80, ack); chk(ack, "R10 low reg ack", int'(ack), 1);
        expect_wr(8'h12, 16'h9ACD);
        send_byte(8'hCD, ack); chk(ack, "R10 low byte ack", int'(ack), 1);
        b_stop();
        tick(4);
        chk(exp_q.size() == 0, "R10 pair committed", exp_q.size(), 0);
        // R10: no pending byte, no write
        b_start();
        send_byte(8'hBA, ack);
        send_byte(8'h80, ack);
        send_byte(8'h11, ack);
        b_stop();
        tick(4);
        chk(bank[8'h12] == 16'h9ACD, "R10 no stray write", int'(bank[8'h12]), 16'h9ACD);

        // R8/R7/R9: burst read across three registers, NACK at the end
        b_start();
        send_byte(8'hBA, ack);
        send_byte(8'h10, ack);
        b_start();
        send_byte(8'hBB, ack); chk(ack, "R8 read addr ack", int'(ack), 1);
        for (int r = 0; r < 3; r++) begin
            recv_byte(1'b1, v);
            chk(v == mdl[8'h10 + r][15:8], "R8 burst hi", int'(v), int'(mdl[8'h10 + r][15:8]));
            recv_byte(r != 2, v);
            chk(v == mdl[8'h10 + r][7:0], "R7 burst lo", int'(v), int'(mdl[8'h10 + r][7:0]));
        end
        tick(H/2);
        chk(sda_oe == 1'b0, "R9 released after nack", int'(sda_oe), 0);
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R9 idle after nack", int'(v), 8'hFF);
        b_stop();

        // R3: foreign address is ignored
        b_start();
        send_byte(8'hA0, ack); chk(!ack, "R3 foreign addr nack", int'(ack), 0);
        send_byte(8'h10, ack); chk(!ack, "R3 ignored byte", int'(ack), 0);
        send_byte(8'h77, ack); chk(!ack, "R3 ignored byte", int'(ack), 0);
        send_byte(8'h66, ack); chk(!ack, "R3 ignored byte", int'(ack), 0);
        b_stop();
        tick(4);
        chk(bank[8'h10] == mdl[8'h10], "R3 no write", int'(bank[8'h10]), int'(mdl[8'h10]));

        // R11: 8-bit read, upper byte then staged lower byte via 0x80
        b_start();
        send_byte(8'hBA, ack);
        send_byte(8'h05, ack);
        b_start();
        send_byte(8'hBB, ack);
        recv_byte(1'b0, v); chk(v == mdl[5][15:8], "R11 upper", int'(v), int'(mdl[5][15:8]));
        b_stop();
        b_start();
        send_byte(8'hBA, ack);
        send_byte(8'h80, ack);
        b_start();
        send_byte(8'hBB, ack);
        recv_byte(1'b0, v); chk(v == mdl[5][7:0], "R11 staged lower", int'(v), int'(mdl[5][7:0]));
        b_stop();

        // R2: start in the middle of a byte restarts framing
        b_start();
        begin
            logic s;
            b_bit(1'b1, s); b_bit(1'b0, s); b_bit(1'b1, s); b_bit(1'b0, s);
        end
        b_start();
        send_byte(8'hBA, ack); chk(ack, "R2 reframed addr ack", int'(ack), 1);
        send_byte(8'h20, ack);
        expect_wr(8'h20, 16'hABCD);
        send_byte(8'hAB, ack);
        send_byte(8'hCD, ack);
        b_stop();
        tick(4);
        chk(exp_q.size() == 0, "R2 write after restart", exp_q.size(), 0);
        chk(sda_oe == 1'b0, "R2 released at stop", int'(sda_oe), 0);

        // R8: read continues from the pointer left by the write
        b_start();
        send_byte(8'hBB, ack);
        recv_byte(1'b1, v); chk(v == mdl[8'h21][15:8], "R8 kept pointer hi", int'(v), int'(mdl[8'h21][15:8]));
        recv_byte(1'b0, v); chk(v == mdl[8'h21][7:0], "R8 kept pointer lo", int'(v), int'(mdl[8'h21][7:0]));
        b_stop();
        tick(4);

        chk(r4_bad == 0, "R4 sda change during scl high", r4_bad, 0);
        chk(r12_bad == 0, "R12 wide write strobe", r12_bad, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule